// File: doc/BRIEF.md
# Programmable I2C SCL Timing Generator

This block produces the SCL clock timing for an I2C master from the system clock. A configuration word chooses a prescale ratio and a gap step. A separate compensation input gives the number of internal ticks that cover SCL rise time, fall time and on-chip delay. The prescaler turns the system clock into an internal tick. The integrator picks the ratio so that this tick stays below 20 MHz. Each SCL period lasts 20 + 8×gap + comp internal ticks. The period is split into a low phase of 10 + 4×gap + comp ticks and a high phase of 10 + 4×gap ticks.

A byte engine raises `run` to request clocking. The block drives SCL low through an open-drain pull signal. It reports a one-cycle pulse at each falling and each rising edge it commands, and it flags the low phase, in which SDA may change, and the sensed-high phase. The high-phase count starts only once SCL is sensed high, so a target that holds SCL low stretches the period. Configuration and compensation are captured only while the generator is idle. A change made during a transfer therefore waits for the next one.

Top module: `scl_timing_gen`

## Requirements
- R1: The internal tick occurs once every (P+1) system clocks, where P is `clk_cfg[2:0]`. Every phase length scales by (P+1).
- R2: The gap value G is `clk_cfg[8:3]` (0 to 63). The compensation value C comes from the `comp` input (0 to 31).
- R3: The time from a `fall_tick` pulse to the following `rise_tick` pulse is (10 + 4G + C)(P+1) system clocks. `scl_pull` is 1 throughout the low phase, and `phase_low` is 1 in exactly those cycles.
- R4: When SCL is not held low externally, consecutive `fall_tick` pulses in one transfer are (20 + 8G + C)(P+1) system clocks apart.
- R5: While `scl_sense` is 0 during the high phase, the high count is frozen. A hold of k cycles lengthens that period by exactly k clocks.
- R6: A change of `clk_cfg` or `comp` while the generator is not idle has no effect on the current transfer. The values present when `idle` is 1 and `run` rises are the ones used.
- R7: If `run` is 0 at the end of a high phase, the generator returns to idle (`idle`=1, `scl_pull`=0) and issues no further `fall_tick`. A transfer begins with a `fall_tick` in the cycle after `run` is sampled 1 while idle.
- R8: After reset, `idle`=1, `scl_pull`=0 and no tick or phase output is active.
- R9: `phase_high` is 1 only in the high phase while `scl_sense` is 1. It is never 1 together with `phase_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Request to keep clocking SCL |
| clk_cfg | input | 9 | [2:0] prescale P, [8:3] gap G |
| comp | input | 5 | Rise/fall/delay compensation C in internal ticks |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull | output | 1 | 1 pulls SCL low (open drain) |
| fall_tick | output | 1 | One-cycle pulse at the start of each low phase |
| rise_tick | output | 1 | One-cycle pulse at the start of each high phase |
| phase_low | output | 1 | Low phase, SDA may change |
| phase_high | output | 1 | High phase with SCL sensed high |
| idle | output | 1 | Generator is idle and captures configuration |

## Verification
`fall_tick` goes high one clock after `run` is seen high while idle. `rise_tick` is due exactly (10 + 4G + C)(P+1) clocks after that. The next `fall_tick` is due (10 + 4G)(P+1) clocks later, plus one clock for each edge at which SCL is held low. A driver task computes these intervals from the configuration in force when the transfer starts and queues them. A monitor samples on the falling clock edge, timestamps each tick pulse, and pops and compares one interval per pulse. The queues must be empty once `idle` returns, which shows that no tick came late, early or extra.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int PRE_W  = 3,
  parameter int GAP_W  = 6,
  parameter int COMP_W = 5,
  localparam int CFG_W = PRE_W + GAP_W,
  localparam int CNT_W = GAP_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CFG_W-1:0]  clk_cfg,
  input  logic [COMP_W-1:0] comp,
  input  logic              scl_sense,
  output logic              scl_pull,
  output logic              fall_tick,
  output logic              rise_tick,
  output logic              phase_low,
  output logic              phase_high,
  output logic              idle
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t               state;
  logic [PRE_W-1:0]  act_pre, pcnt;
  logic [GAP_W-1:0]  act_gap;
  logic [COMP_W-1:0] act_comp;
  logic [CNT_W-1:0]  cnt, hi_len, lo_len;
  logic              hold, ce;

  assign hi_len = CNT_W'(10) + (CNT_W'(act_gap) << 2);
  assign lo_len = hi_len + CNT_W'(act_comp);
  assign hold   = (state == S_HIGH) && !scl_sense;
  assign ce     = (pcnt == act_pre) && !hold;

  assign scl_pull   = (state == S_LOW);
  assign phase_low  = (state == S_LOW);
  assign phase_high = (state == S_HIGH) && scl_sense;
  assign idle       = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      act_pre   <= '0;
      act_gap   <= '0;
      act_comp  <= '0;
      pcnt      <= '0;
      cnt       <= '0;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      if (state == S_IDLE || hold || ce) pcnt <= '0;
      else                                pcnt <= pcnt + 1'b1;
      case (state)
        S_IDLE: begin
          act_pre  <= clk_cfg[PRE_W-1:0];
          act_gap  <= clk_cfg[CFG_W-1:PRE_W];
          act_comp <= comp;
          cnt      <= '0;
          if (run) begin
            state     <= S_LOW;
            fall_tick <= 1'b1;
          end
        end
        S_LOW: if (ce) begin
          if (cnt == lo_len - 1'b1) begin
            cnt       <= '0;
            state     <= S_HIGH;
            rise_tick <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_HIGH: if (ce) begin
          if (cnt == hi_len - 1'b1) begin
            cnt <= '0;
            if (run) begin
              state     <= S_LOW;
              fall_tick <= 1'b1;
            end else state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (pcnt <= act_pre));

  a_r3_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (!scl_pull && $past(state == S_LOW)));

  a_r5_stretch_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(cnt) && state == S_HIGH));

  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> ($stable(act_pre) && $stable(act_gap) && $stable(act_comp)));

  a_r7_fall_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> $past(run));

  a_r9_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_low && phase_high));

endmodule

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [8:0] clk_cfg = '0;
  logic [4:0] comp = '0;
  logic       stretch = 1'b0;
  logic       scl_sense;
  logic       scl_pull, fall_tick, rise_tick, phase_low, phase_high, idle;

  int checks = 0;
  int fails  = 0;
  int stretch_len = 0;
  int qlow[$];
  int qper[$];
  string tag = "R8";

  always #2.5 clk = ~clk;
  assign scl_sense = !(scl_pull || stretch);

  scl_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_cfg(clk_cfg), .comp(comp),
    .scl_sense(scl_sense), .scl_pull(scl_pull), .fall_tick(fall_tick),
    .rise_tick(rise_tick), .phase_low(phase_low), .phase_high(phase_high),
    .idle(idle));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  int  t = 0;
  int  last_fall = 0, lo_start = 0;
  bit  have_last = 0;
  bit  r9_bad = 0;
  always @(negedge clk) begin
    t++;
    if (rst_n) begin
      if (phase_high && !scl_sense) r9_bad = 1;
      if (phase_low != scl_pull) check(0, "R3 phase_low", phase_low, scl_pull);
      if (fall_tick) begin
        if (have_last) begin
          if (qper.size() == 0) check(0, {tag, " unexpected fall"}, t - last_fall, 0);
          else begin
            int e;
            e = qper.pop_front();
            check((t - last_fall) == e, {tag, " R4 period"}, t - last_fall, e);
          end
        end
        last_fall = t;
        lo_start  = t;
        have_last = 1;
      end
      if (rise_tick) begin
        if (qlow.size() == 0) check(0, {tag, " unexpected rise"}, t - lo_start, 0);
        else begin
          int e;
          e = qlow.pop_front();
          check((t - lo_start) == e, {tag, " R3 low length"}, t - lo_start, e);
        end
      end
      if (idle) have_last = 0;
    end
  end

  // target clock stretching model
  initial forever begin
    @(negedge clk);
    if (stretch_len > 0 && rise_tick) begin
      repeat (stretch_len) @(negedge clk);
      stretch = 1'b0;
    end else if (stretch_len > 0 && phase_low) stretch = 1'b1;
  end

  // driver: one transfer of n SCL periods
  task automatic burst(input int pre, input int gap, input int c, input int n,
                       input int s, input bit chg, input string req);
    int lo, per;
    lo  = (10 + 4*gap + c) * (pre + 1);
    per = (20 + 8*gap + c) * (pre + 1) + s;
    tag = req;
    for (int i = 0; i < n; i++) qlow.push_back(lo);
    for (int i = 0; i < n - 1; i++) qper.push_back(per);
    @(negedge clk);
    clk_cfg = {gap[5:0], pre[2:0]};
    comp = c[4:0];
    stretch_len = s;
    run = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rise_tick) @(negedge clk);
      if (chg && i == 0) begin
        clk_cfg = 9'h1FF ^ clk_cfg;
        comp = ~comp;
      end
    end
    run = 1'b0;
    while (!idle) @(negedge clk);
    stretch_len = 0;
    stretch = 1'b0;
    repeat (3) @(negedge clk);
    check(qlow.size() == 0 && qper.size() == 0, {req, " R7 queues drained"},
          qlow.size() + qper.size(), 0);
    check(idle && !scl_pull && !fall_tick, {req, " R7 idle after run low"},
          {idle, scl_pull, fall_tick}, 3'b100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(idle && !scl_pull && !fall_tick && !rise_tick && !phase_low && !phase_high,
          "R8 reset outputs", {idle, scl_pull, fall_tick, rise_tick}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(idle && !scl_pull, "R8 idle after reset", {idle, scl_pull}, 2'b10);
    burst(0, 0, 0, 3, 0, 0, "R1 min");
    burst(3, 5, 7, 3, 0, 0, "R2 mid");
    burst(7, 63, 31, 2, 0, 0, "R1 R2 max");
    burst(1, 2, 3, 3, 13, 0, "R5 stretch");
    burst(2, 1, 4, 3, 0, 1, "R6 change mid");
    burst(5, 62, 27, 2, 0, 0, "R6 new cfg");
    check(!r9_bad, "R9 phase_high while low sensed", r9_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule